// File: doc/BRIEF.md
# Delayed Write Completion Discard Timer

This block holds the completions of delayed write transactions in a small in-order queue inside a bus bridge. It also bounds how long each completion may wait for its initiator. When an entry reaches the head of the queue, a down-counter is loaded from a software-programmable count value. If the initiator comes back with a retry whose tag matches the head entry before the counter runs out, the completion is delivered and popped. If the counter runs out first, the entry is dropped without being delivered. A system-error request then goes out, but only while the error enable input allows it.

New delayed writes are taken only while the queue has a free slot. Otherwise the requester is told to retry. The counter runs only while an entry sits at the head. Each new head entry gets a fresh load of the programmed value, taken in its first cycle at the head.

Top module: `dwc_discard_ctrl`

## Requirements
- R1: After reset, empty_o is 1, full_o is 0, and deliver_o, discard_o, serr_req_o and push_retry_o are 0 while no request is applied.
- R2: Accepted pushes are delivered in the order they were pushed, each with its own tag on deliver_tag_o.
- R3: A push while full_o is 1 is refused: push_retry_o is 1 in that cycle and the tag is never stored or delivered.
- R4: The counter is loaded from discard_cnt_i in the first cycle an entry is at the head. With a loaded value N, discard_o is 1 in the (N+1)-th cycle at the head and the entry is then popped. A later change of discard_cnt_i does not affect an entry that is already counting.
- R5: A loaded value of zero discards the entry in its first cycle at the head.
- R6: A retry whose tag equals the head tag, with retry_valid_i at 1, drives deliver_o to 1 with deliver_tag_o equal to that tag in the same cycle, and pops the entry without a discard.
- R7: A retry with a non-matching tag causes no delivery and no pop, and the counter keeps running.
- R8: After a discard or delivery, the next entry becomes head and gets a fresh counter load.
- R9: serr_req_o is 1 in the discard cycle when serr_en_i is 1, and stays 0 on a discard when serr_en_i is 0.
- R10: A push and a pop in the same cycle leave the occupancy unchanged.
- R11: full_o is 1 when DEPTH entries are held and empty_o is 1 when none are held.
- R12: When a matching retry arrives in the cycle the counter expires, the entry is delivered and not discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| push_valid_i | input | 1 | New delayed write completion to queue |
| push_tag_i | input | TAG_W | Tag of the new completion |
| push_retry_o | output | 1 | Push refused because the queue is full |
| retry_valid_i | input | 1 | Initiator repeats a delayed write |
| retry_tag_i | input | TAG_W | Tag of the repeated write |
| discard_cnt_i | input | CNT_W | Programmed initial counter value |
| serr_en_i | input | 1 | Enables the error request on a discard |
| deliver_o | output | 1 | Head completion delivered this cycle |
| deliver_tag_o | output | TAG_W | Tag of the delivered completion |
| discard_o | output | 1 | Head completion dropped this cycle |
| serr_req_o | output | 1 | System-error request pulse |
| full_o | output | 1 | Queue holds DEPTH entries |
| empty_o | output | 1 | Queue holds no entries |

## Verification
The assertions assume that the queue never sees a write while full and never sees a read while empty. They also assume that a same-cycle push and pop leaves the count alone and that a running counter steps down by one per cycle. The first two depend on the top gating pushes with full_o and on the timer popping only a present head. The bench drives pushes, retries and count changes only just after a falling clock edge and holds them for a whole cycle. It pushes against a full queue only to observe the refusal, so every internal write stays within the assumed limits.

// File: rtl/dwc_pkg.sv
package dwc_pkg;
  typedef enum logic {
    TMR_IDLE = 1'b0,
    TMR_RUN  = 1'b1
  } tmr_state_e;
endpackage

// File: rtl/dwc_cmpl_fifo.sv
module dwc_cmpl_fifo #(
  parameter int DEPTH = 4,
  parameter int TAG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic             rd_i,
  output logic [TAG_W-1:0] head_tag_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [TAG_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [OCC_W-1:0] occ_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      occ_q    <= '0;
    end else begin
      if (wr_i) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (rd_i) rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      if (wr_i && !rd_i)      occ_q <= occ_q + 1'b1;
      else if (rd_i && !wr_i) occ_q <= occ_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_i) mem_q[wr_ptr_q] <= wr_tag_i;
  end

  assign head_tag_o = mem_q[rd_ptr_q];
  assign empty_o    = (occ_q == '0);
  assign full_o     = (occ_q == OCC_W'(DEPTH));

  assert_no_overflow_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> !full_o);
  assert_no_underflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |-> !empty_o);
  assert_occ_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && rd_i) |=> (occ_q == $past(occ_q)));
endmodule

// File: rtl/dwc_discard_timer.sv
module dwc_discard_timer
  import dwc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int TAG_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             head_valid_i,
  input  logic [TAG_W-1:0] head_tag_i,
  input  logic             retry_valid_i,
  input  logic [TAG_W-1:0] retry_tag_i,
  input  logic [CNT_W-1:0] cnt_init_i,
  input  logic             serr_en_i,
  output logic             pop_o,
  output logic             deliver_o,
  output logic             discard_o,
  output logic             serr_req_o
);
  tmr_state_e       state_q;
  logic [CNT_W-1:0] remain_q;
  logic [CNT_W-1:0] cnt_now;
  logic             match, expire;

  // first head cycle uses the programmed value directly
  assign cnt_now = (state_q == TMR_IDLE) ? cnt_init_i : remain_q;
  assign match   = head_valid_i && retry_valid_i && (retry_tag_i == head_tag_i);
  assign expire  = head_valid_i && (cnt_now == '0);

  assign deliver_o  = match;
  assign discard_o  = expire && !match;
  assign pop_o      = match || expire;
  assign serr_req_o = discard_o && serr_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= TMR_IDLE;
      remain_q <= '0;
    end else if (pop_o || !head_valid_i) begin
      state_q  <= TMR_IDLE;
    end else begin
      state_q  <= TMR_RUN;
      remain_q <= cnt_now - CNT_W'(1);
    end
  end

  assert_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TMR_IDLE && head_valid_i && !pop_o)
      |=> (state_q == TMR_RUN && remain_q == $past(cnt_init_i) - CNT_W'(1)));
  assert_count_down_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == TMR_RUN && head_valid_i && !pop_o)
      |=> (remain_q == $past(remain_q) - CNT_W'(1)));
endmodule

// File: rtl/dwc_discard_ctrl.sv
module dwc_discard_ctrl #(
  parameter int DEPTH = 4,
  parameter int TAG_W = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_valid_i,
  input  logic [TAG_W-1:0] push_tag_i,
  output logic             push_retry_o,
  input  logic             retry_valid_i,
  input  logic [TAG_W-1:0] retry_tag_i,
  input  logic [CNT_W-1:0] discard_cnt_i,
  input  logic             serr_en_i,
  output logic             deliver_o,
  output logic [TAG_W-1:0] deliver_tag_o,
  output logic             discard_o,
  output logic             serr_req_o,
  output logic             full_o,
  output logic             empty_o
);
  logic             push_acc, pop;
  logic [TAG_W-1:0] head_tag;

  assign push_acc     = push_valid_i && !full_o;
  assign push_retry_o = push_valid_i && full_o;

  dwc_cmpl_fifo #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_fifo (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (push_acc),
    .wr_tag_i   (push_tag_i),
    .rd_i       (pop),
    .head_tag_o (head_tag),
    .empty_o    (empty_o),
    .full_o     (full_o)
  );

  dwc_discard_timer #(.CNT_W(CNT_W), .TAG_W(TAG_W)) u_timer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .head_valid_i  (!empty_o),
    .head_tag_i    (head_tag),
    .retry_valid_i (retry_valid_i),
    .retry_tag_i   (retry_tag_i),
    .cnt_init_i    (discard_cnt_i),
    .serr_en_i     (serr_en_i),
    .pop_o         (pop),
    .deliver_o     (deliver_o),
    .discard_o     (discard_o),
    .serr_req_o    (serr_req_o)
  );

  assign deliver_tag_o = head_tag;

  assert_pop_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deliver_o |-> !discard_o);
endmodule

// File: tb/dwc_discard_ctrl_tb_top.sv
module dwc_discard_ctrl_tb_top;
  localparam int DEPTH = 4;
  localparam int TAG_W = 8;
  localparam int CNT_W = 16;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic push_valid_i = 1'b0;
  logic [TAG_W-1:0] push_tag_i = '0;
  logic push_retry_o;
  logic retry_valid_i = 1'b0;
  logic [TAG_W-1:0] retry_tag_i = '0;
  logic [CNT_W-1:0] discard_cnt_i = '0;
  logic serr_en_i = 1'b0;
  logic deliver_o;
  logic [TAG_W-1:0] deliver_tag_o;
  logic discard_o, serr_req_o, full_o, empty_o;

  int errs = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;

  dwc_discard_ctrl #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .push_valid_i(push_valid_i), .push_tag_i(push_tag_i), .push_retry_o(push_retry_o),
    .retry_valid_i(retry_valid_i), .retry_tag_i(retry_tag_i),
    .discard_cnt_i(discard_cnt_i), .serr_en_i(serr_en_i),
    .deliver_o(deliver_o), .deliver_tag_o(deliver_tag_o),
    .discard_o(discard_o), .serr_req_o(serr_req_o),
    .full_o(full_o), .empty_o(empty_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // advance one clock; inputs change just after the falling edge, sample 1ns later
  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
    #1;
  endtask

  task automatic idle_in();
    push_valid_i = 1'b0;
    retry_valid_i = 1'b0;
    #1;
  endtask

  task automatic push_one(input logic [TAG_W-1:0] t);
    push_valid_i = 1'b1; push_tag_i = t; #1;
    tick();
    push_valid_i = 1'b0; #1;
  endtask

  task automatic t_reset();
    chk("R1", "empty_o", empty_o, 1);
    chk("R1", "full_o", full_o, 0);
    chk("R1", "deliver|discard|serr|retry", int'({deliver_o, discard_o, serr_req_o, push_retry_o}), 0);
  endtask

  task automatic t_expire();
    discard_cnt_i = 16'd3; serr_en_i = 1'b1;
    push_one(8'hA1);                 // head cycle 0
    for (int c = 0; c < 3; c++) begin
      chk("R4", "discard_o before expiry", discard_o, 0);
      tick();
    end
    chk("R4", "discard_o at cycle N", discard_o, 1);
    chk("R9", "serr_req_o with enable", serr_req_o, 1);
    tick();
    chk("R4", "empty after discard", empty_o, 1);
    serr_en_i = 1'b0;
  endtask

  task automatic t_zero();
    discard_cnt_i = 16'd0; serr_en_i = 1'b0;
    push_one(8'hB2);
    chk("R5", "discard_o first head cycle", discard_o, 1);
    chk("R9", "serr_req_o without enable", serr_req_o, 0);
    tick();
    chk("R5", "empty after zero count", empty_o, 1);
  endtask

  task automatic t_deliver();
    discard_cnt_i = 16'd10;
    push_one(8'hC3);
    tick();
    retry_valid_i = 1'b1; retry_tag_i = 8'h55; #1;
    chk("R7", "deliver_o on wrong tag", deliver_o, 0);
    tick();
    chk("R7", "entry kept after wrong tag", empty_o, 0);
    retry_tag_i = 8'hC3; #1;
    chk("R6", "deliver_o on match", deliver_o, 1);
    chk("R6", "deliver_tag_o", deliver_tag_o, 8'hC3);
    chk("R6", "discard_o on match", discard_o, 0);
    tick();
    idle_in();
    chk("R6", "empty after delivery", empty_o, 1);
  endtask

  task automatic t_fill();
    discard_cnt_i = 16'd500;
    for (int i = 0; i < DEPTH; i++) push_one(TAG_W'(8'h10 + i));
    chk("R11", "full_o at DEPTH", full_o, 1);
    push_valid_i = 1'b1; push_tag_i = 8'hEE; #1;
    chk("R3", "push_retry_o when full", push_retry_o, 1);
    tick();
    push_valid_i = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      retry_valid_i = 1'b1; retry_tag_i = TAG_W'(8'h10 + i); #1;
      chk("R2", "delivered tag order", deliver_o ? int'(deliver_tag_o) : -1, 8'h10 + i);
      tick();
    end
    idle_in();
    chk("R3", "refused tag not stored", empty_o, 1);
  endtask

  task automatic t_push_pop();
    discard_cnt_i = 16'd500;
    for (int i = 0; i < 3; i++) push_one(TAG_W'(8'h20 + i));
    push_valid_i = 1'b1; push_tag_i = 8'h23;
    retry_valid_i = 1'b1; retry_tag_i = 8'h20; #1;
    chk("R10", "pop in push cycle", deliver_o, 1);
    tick();
    idle_in();
    chk("R10", "not full after push+pop", full_o, 0);
    push_one(8'h24);
    chk("R10", "full after one more push", full_o, 1);
    for (int i = 0; i < DEPTH; i++) begin
      retry_valid_i = 1'b1; retry_tag_i = TAG_W'(8'h21 + i); #1;
      tick();
    end
    idle_in();
    chk("R11", "empty_o after drain", empty_o, 1);
  endtask

  task automatic t_chain();
    discard_cnt_i = 16'd2;
    push_valid_i = 1'b1; push_tag_i = 8'h31; #1;
    tick();                              // first entry head cycle 0
    push_tag_i = 8'h32; #1;
    chk("R8", "no discard first cycle", discard_o, 0);
    tick();                              // cycle 1; second stored
    push_valid_i = 1'b0; discard_cnt_i = 16'd1; #1;
    chk("R4", "no discard at cycle 1", discard_o, 0);
    tick();
    chk("R4", "loaded value kept after reprogram", discard_o, 1);
    tick();                              // second entry head cycle 0, loads 1
    chk("R8", "fresh head no discard", discard_o, 0);
    tick();
    chk("R8", "fresh head discard with new value", discard_o, 1);
    tick();
    chk("R8", "empty after chain", empty_o, 1);
  endtask

  task automatic t_race();
    discard_cnt_i = 16'd1;
    push_one(8'h41);
    tick();
    retry_valid_i = 1'b1; retry_tag_i = 8'h41; #1;
    chk("R12", "deliver on expiry cycle", deliver_o, 1);
    chk("R12", "no discard on expiry cycle", discard_o, 0);
    tick();
    idle_in();
    chk("R12", "empty after race", empty_o, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    t_reset();
    rst_ni = 1'b1;
    tick();
    t_reset();
    t_expire();
    t_zero();
    t_deliver();
    t_fill();
    t_push_pop();
    t_chain();
    t_race();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule